// File: doc/BRIEF.md
# Bus Error Status Logger with Locking

This block records bus errors for a slave that several initiating masters can reach. When an error strobe arrives, the block writes the error type into that master's status field. It writes the transfer address into one shared address register. Two masters can request locking, and each has its own status field. That field holds the type bits, a field-lock bit and an address-lock bit. Error strobes that carry any other master ID are not logged.

A master can qualify a transfer to ask for error locking. A locked status field keeps its contents when later errors arrive from the same master. The first locking master also takes the single address lock. While that lock is held, no error from any master changes the address register. Software reads the fields through a small register port and clears bits by writing ones (write-one-to-clear). It is expected to clear the type bits and both lock bits in one write.

Top module: `errlog_top`

## Requirements
- R1: After reset, both status fields and the address register read as zero.
- R2: An error from master 0 or 1 whose status field is not locked stores `errType` in bits [3:0] of that field. When no address lock is held, the address register also takes `errAddr`. Among unlocked errors, the most recent one is kept.
- R3: An error logged with `errLockReq` high sets the field-lock bit (bit 4) of that master's field. A logged error with `errLockReq` low leaves bit 4 at zero.
- R4: While a master's field-lock bit is 1, errors from that master change neither its field nor the address register.
- R5: A logged locking error sets that master's address-lock bit (bit 5) only if no address-lock bit is set in either field. At most one address-lock bit is ever set.
- R6: While any address-lock bit is set, no error from any master changes the address register.
- R7: Error strobes with a master ID of 2 or more change no register.
- R8: A write with `regSel` 0 or 1 clears each status bit where `regWrData` holds a 1 and leaves the other bits unchanged. A write with `regSel` 2 or 3 changes nothing.
- R9: A clear and a logged error can hit the same field in the same cycle. In that case the error wins: the type and field-lock bit take the error's values. The address-lock bit becomes the cleared old value ORed with any newly taken lock.
- R10: The read port is combinational. `regSel` 0 and 1 return the status fields, zero-extended. `regSel` 2 returns the address register. `regSel` 3 returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| errValid | input | 1 | Error strobe, one per detected error |
| errType | input | 4 | Error type bits to record |
| errMaster | input | 3 | ID of the master that started the failing transfer |
| errLockReq | input | 1 | Transfer was qualified for error locking |
| errAddr | input | 32 | Address of the failing transfer |
| regSel | input | 2 | Register select for read and clear |
| regWrEn | input | 1 | Clear strobe (write-one-to-clear) |
| regWrData | input | 32 | Clear mask |
| regRdData | output | 32 | Read data for the selected register |

## Verification
The bench uses the default build: two lock-capable masters, a 3-bit master ID and a 2-bit register select. The 3-bit ID lets the bench drive ignored IDs 2 through 7 next to the two logged masters. The 2-bit select reaches the unused slot 3, so the zero read-back and the ignored writes to the address slot can both be observed. Random traffic favours masters 0 and 1 and mixes in lock requests and partial clears. This makes contention for the address lock, and clears that collide with errors in the same cycle, occur many times.

// File: rtl/errlog_pkg.sv
package errlog_pkg;
  localparam int ERR_MASTERS  = 2;
  localparam int ERR_TYPE_W   = 4;
  localparam int FLD_LOCK_BIT = ERR_TYPE_W;
  localparam int ADR_LOCK_BIT = ERR_TYPE_W + 1;
  localparam int STAT_W       = ERR_TYPE_W + 2;

  typedef struct packed {
    logic [ERR_MASTERS-1:0] fieldWr;
    logic [ERR_MASTERS-1:0] takeAddrLock;
    logic [ERR_MASTERS-1:0] clrHit;
    logic                   addrWr;
  } strobes_t;
endpackage

// File: rtl/errlog_ctrl.sv
module errlog_ctrl
  import errlog_pkg::*;
#(
  parameter int ID_W  = 3,
  parameter int SEL_W = 2
) (
  input  logic                   errValid,
  input  logic [ID_W-1:0]        errMaster,
  input  logic                   errLockReq,
  input  logic                   regWrEn,
  input  logic [SEL_W-1:0]       regSel,
  input  logic [ERR_MASTERS-1:0] fieldLockQ,
  input  logic [ERR_MASTERS-1:0] addrLockQ,
  output strobes_t               strb
);
  logic anyAddrLock;
  logic [ERR_MASTERS-1:0] idHit;
  logic [ERR_MASTERS-1:0] selHit;

  assign anyAddrLock = |addrLockQ;

  for (genvar g = 0; g < ERR_MASTERS; g++) begin : gDecode
    localparam logic [ID_W-1:0]  MID = ID_W'(g);
    localparam logic [SEL_W-1:0] MSEL = SEL_W'(g);
    assign idHit[g]  = errValid && (errMaster == MID);
    assign selHit[g] = regWrEn && (regSel == MSEL);
  end

  always_comb begin
    strb = '0;
    for (int m = 0; m < ERR_MASTERS; m++) begin
      strb.fieldWr[m]      = idHit[m] && !fieldLockQ[m];
      strb.takeAddrLock[m] = idHit[m] && !fieldLockQ[m] && errLockReq && !anyAddrLock;
      strb.clrHit[m]       = selHit[m];
    end
    strb.addrWr = (|strb.fieldWr) && !anyAddrLock;
  end
endmodule

// File: rtl/errlog_datapath.sv
module errlog_datapath
  import errlog_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int SEL_W  = 2
) (
  input  logic                               clk,
  input  logic                               rstN,
  input  strobes_t                           strb,
  input  logic [ERR_TYPE_W-1:0]              errType,
  input  logic                               errLockReq,
  input  logic [ADDR_W-1:0]                  errAddr,
  input  logic [SEL_W-1:0]                   regSel,
  input  logic [DATA_W-1:0]                  regWrData,
  output logic [ERR_MASTERS-1:0][STAT_W-1:0] statusQ,
  output logic [ADDR_W-1:0]                  addrQ,
  output logic [DATA_W-1:0]                  regRdData
);
  logic [STAT_W-1:0] clrMask;
  assign clrMask = regWrData[STAT_W-1:0];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      statusQ <= '0;
    end else begin
      for (int m = 0; m < ERR_MASTERS; m++) begin
        if (strb.fieldWr[m]) begin
          statusQ[m][ERR_TYPE_W-1:0] <= errType;
          statusQ[m][FLD_LOCK_BIT]   <= errLockReq;
          statusQ[m][ADR_LOCK_BIT]   <= (statusQ[m][ADR_LOCK_BIT]
                                         & ~(strb.clrHit[m] & clrMask[ADR_LOCK_BIT]))
                                        | strb.takeAddrLock[m];
        end else if (strb.clrHit[m]) begin
          statusQ[m] <= statusQ[m] & ~clrMask;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) addrQ <= '0;
    else if (strb.addrWr) addrQ <= errAddr;
  end

  always_comb begin
    regRdData = '0;
    for (int m = 0; m < ERR_MASTERS; m++) begin
      if (regSel == SEL_W'(m)) regRdData = DATA_W'(statusQ[m]);
    end
    if (regSel == SEL_W'(ERR_MASTERS)) regRdData = DATA_W'(addrQ);
  end
endmodule

// File: rtl/errlog_top.sv
module errlog_top
  import errlog_pkg::*;
#(
  parameter int ID_W   = 3,
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  localparam int SEL_W = $clog2(ERR_MASTERS + 1)
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  errValid,
  input  logic [ERR_TYPE_W-1:0] errType,
  input  logic [ID_W-1:0]       errMaster,
  input  logic                  errLockReq,
  input  logic [ADDR_W-1:0]     errAddr,
  input  logic [SEL_W-1:0]      regSel,
  input  logic                  regWrEn,
  input  logic [DATA_W-1:0]     regWrData,
  output logic [DATA_W-1:0]     regRdData
);
  strobes_t                           strb;
  logic [ERR_MASTERS-1:0][STAT_W-1:0] statusQ;
  logic [ADDR_W-1:0]                  addrQ;
  logic [ERR_MASTERS-1:0]             fieldLockQ;
  logic [ERR_MASTERS-1:0]             addrLockQ;

  for (genvar g = 0; g < ERR_MASTERS; g++) begin : gLockTap
    assign fieldLockQ[g] = statusQ[g][FLD_LOCK_BIT];
    assign addrLockQ[g]  = statusQ[g][ADR_LOCK_BIT];
  end

  errlog_ctrl #(.ID_W(ID_W), .SEL_W(SEL_W)) uCtrl (
    .errValid   (errValid),
    .errMaster  (errMaster),
    .errLockReq (errLockReq),
    .regWrEn    (regWrEn),
    .regSel     (regSel),
    .fieldLockQ (fieldLockQ),
    .addrLockQ  (addrLockQ),
    .strb       (strb)
  );

  errlog_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SEL_W(SEL_W)) uData (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .errType    (errType),
    .errLockReq (errLockReq),
    .errAddr    (errAddr),
    .regSel     (regSel),
    .regWrData  (regWrData),
    .statusQ    (statusQ),
    .addrQ      (addrQ),
    .regRdData  (regRdData)
  );
endmodule

// File: rtl/errlog_checker.sv
module errlog_checker
  import errlog_pkg::*;
#(
  parameter int ID_W   = 3,
  parameter int ADDR_W = 32,
  parameter int SEL_W  = 2
) (
  input logic                               clk,
  input logic                               rstN,
  input logic                               errValid,
  input logic [ID_W-1:0]                    errMaster,
  input logic                               errLockReq,
  input logic                               regWrEn,
  input logic [SEL_W-1:0]                   regSel,
  input logic [ERR_MASTERS-1:0][STAT_W-1:0] statusQ,
  input logic [ADDR_W-1:0]                  addrQ
);
  localparam logic [ID_W-1:0] FIRST_IGNORED = ID_W'(ERR_MASTERS);

  logic [ERR_MASTERS-1:0] adrLocks;
  for (genvar g = 0; g < ERR_MASTERS; g++) begin : gTap
    assign adrLocks[g] = statusQ[g][ADR_LOCK_BIT];
  end

  AST_ADDR_LOCK_UNIQUE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(adrLocks)); // R5

  AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (|adrLocks) |=> $stable(addrQ)); // R6

  AST_IGNORED_ID: assert property (@(posedge clk) disable iff (!rstN)
    (errValid && errMaster >= FIRST_IGNORED && !regWrEn)
      |=> ($stable(statusQ) && $stable(addrQ))); // R7

  for (genvar g = 0; g < ERR_MASTERS; g++) begin : gPer
    localparam logic [ID_W-1:0]  MID  = ID_W'(g);
    localparam logic [SEL_W-1:0] MSEL = SEL_W'(g);

    AST_FIELD_LOCK_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
      (statusQ[g][FLD_LOCK_BIT] && !(regWrEn && regSel == MSEL))
        |=> ($stable(statusQ[g][ERR_TYPE_W-1:0]) && statusQ[g][FLD_LOCK_BIT])); // R4

    AST_LOCK_TAKEN: assert property (@(posedge clk) disable iff (!rstN)
      (errValid && errMaster == MID && !statusQ[g][FLD_LOCK_BIT] && errLockReq)
        |=> statusQ[g][FLD_LOCK_BIT]); // R3
  end
endmodule

bind errlog_top errlog_checker #(.ID_W(ID_W), .ADDR_W(ADDR_W), .SEL_W(SEL_W)) uChk (
  .clk        (clk),
  .rstN       (rstN),
  .errValid   (errValid),
  .errMaster  (errMaster),
  .errLockReq (errLockReq),
  .regWrEn    (regWrEn),
  .regSel     (regSel),
  .statusQ    (statusQ),
  .addrQ      (addrQ)
);

// File: tb/tb_errlog_top.sv
`timescale 1ns/100ps
module tb_errlog_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        errValid = 1'b0;
  logic [3:0]  errType = '0;
  logic [2:0]  errMaster = '0;
  logic        errLockReq = 1'b0;
  logic [31:0] errAddr = '0;
  logic [1:0]  regSel = '0;
  logic        regWrEn = 1'b0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 1'b0;

  logic [3:0]  mType [2];
  logic        mFl [2];
  logic        mAl [2];
  logic [31:0] mAddr;

  always #2.5 clk = ~clk;

  errlog_top dut (
    .clk(clk), .rstN(rstN), .errValid(errValid), .errType(errType),
    .errMaster(errMaster), .errLockReq(errLockReq), .errAddr(errAddr),
    .regSel(regSel), .regWrEn(regWrEn), .regWrData(regWrData),
    .regRdData(regRdData)
  );

  function automatic logic [31:0] expRead(input int s);
    if (s < 2) return {26'd0, mAl[s], mFl[s], mType[s]};
    if (s == 2) return mAddr;
    return 32'd0;
  endfunction

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    nChecks++;
    if (got !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", tag, got, exp);
    end
  endtask

  task automatic modelClock(input logic v, input logic [3:0] t, input logic [2:0] id,
                            input logic lk, input logic [31:0] a, input logic we,
                            input logic [1:0] sel, input logic [31:0] wd);
    logic anyAl;
    logic [3:0] nT [2];
    logic nFl [2];
    logic nAl [2];
    logic [31:0] nAddr;
    anyAl = mAl[0] | mAl[1];
    nAddr = mAddr;
    for (int m = 0; m < 2; m++) begin
      logic fw, clr;
      fw  = v && (id == 3'(m)) && !mFl[m];
      clr = we && (sel == 2'(m));
      nT[m] = mType[m]; nFl[m] = mFl[m]; nAl[m] = mAl[m];
      if (fw) begin
        nT[m]  = t;
        nFl[m] = lk;
        nAl[m] = (mAl[m] & ~(clr & wd[5])) | (lk & ~anyAl);
        if (!anyAl) nAddr = a;
      end else if (clr) begin
        nT[m]  = mType[m] & ~wd[3:0];
        nFl[m] = mFl[m] & ~wd[4];
        nAl[m] = mAl[m] & ~wd[5];
      end
    end
    for (int m = 0; m < 2; m++) begin
      mType[m] = nT[m]; mFl[m] = nFl[m]; mAl[m] = nAl[m];
    end
    mAddr = nAddr;
  endtask

  task automatic sweep(input string tag);
    for (int s = 0; s < 4; s++) begin
      regSel = 2'(s);
      #0.2;
      chk(tag, regRdData, expRead(s));
    end
  endtask

  task automatic step(input string tag, input logic v, input logic [3:0] t,
                      input logic [2:0] id, input logic lk, input logic [31:0] a,
                      input logic we, input logic [1:0] sel, input logic [31:0] wd);
    @(negedge clk);
    errValid = v; errType = t; errMaster = id; errLockReq = lk; errAddr = a;
    regWrEn = we; regSel = sel; regWrData = wd;
    @(posedge clk);
    modelClock(v, t, id, lk, a, we, sel, wd);
    #1;
    errValid = 1'b0; regWrEn = 1'b0;
    sweep(tag);
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      nFails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    int unused;
    unused = $urandom(32'h1c3d);
    for (int m = 0; m < 2; m++) begin mType[m] = '0; mFl[m] = 0; mAl[m] = 0; end
    mAddr = '0;
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1'b1;
    #0.5;
    sweep("R1 reset state");

    step("R2 plain error m0", 1, 4'h3, 3'd0, 0, 32'hA000_0001, 0, 2'd0, 0);
    chk("R2 literal type", {26'd0, mAl[0], mFl[0], mType[0]}, 32'h3);
    step("R3 R5 lock m1", 1, 4'h5, 3'd1, 1, 32'hA000_0002, 0, 2'd0, 0);
    regSel = 2'd1; #0.2; chk("R3 R5 literal m1", regRdData, 32'h35);
    step("R5 R6 second locker", 1, 4'h9, 3'd0, 1, 32'hA000_0003, 0, 2'd0, 0);
    regSel = 2'd2; #0.2; chk("R6 literal addr held", regRdData, 32'hA000_0002);
    step("R4 locked field m0", 1, 4'h2, 3'd0, 0, 32'hA000_0004, 0, 2'd0, 0);
    step("R7 ignored id", 1, 4'hF, 3'd5, 1, 32'hA000_0005, 0, 2'd0, 0);
    step("R7 ignored id 7", 1, 4'hE, 3'd7, 0, 32'hA000_0006, 0, 2'd0, 0);
    step("R8 write to addr slot", 0, 4'h0, 3'd0, 0, 0, 1, 2'd2, 32'hFFFF_FFFF);
    step("R8 write to slot 3", 0, 4'h0, 3'd0, 0, 0, 1, 2'd3, 32'hFFFF_FFFF);
    step("R8 partial clear", 0, 4'h0, 3'd0, 0, 0, 1, 2'd1, 32'h20);
    step("R4 m1 still field locked", 1, 4'h1, 3'd1, 0, 32'hA000_0007, 0, 2'd0, 0);
    step("R8 clear all m0", 0, 4'h0, 3'd0, 0, 0, 1, 2'd0, 32'h3F);
    step("R6 released addr", 1, 4'h6, 3'd0, 0, 32'hA000_0008, 0, 2'd0, 0);
    step("R9 clear vs error", 1, 4'hC, 3'd0, 1, 32'hA000_0009, 1, 2'd0, 32'hFFFF_FFFF);
    regSel = 2'd0; #0.2; chk("R9 literal m0", regRdData, 32'h3C);
    step("R8 clear m0", 0, 4'h0, 3'd0, 0, 0, 1, 2'd0, 32'h3F);
    step("R8 clear m1", 0, 4'h0, 3'd0, 0, 0, 1, 2'd1, 32'h3F);
    step("R10 R2 last wins", 1, 4'hA, 3'd1, 0, 32'hB000_0000, 0, 2'd0, 0);
    step("R10 R2 last wins 2", 1, 4'h4, 3'd1, 0, 32'hB000_0001, 0, 2'd0, 0);

    for (int i = 0; i < 3000; i++) begin
      logic v, lk, we;
      logic [2:0] id;
      logic [1:0] sel;
      logic [31:0] wd;
      int r;
      r  = $urandom;
      v  = ($urandom % 2) == 0;
      lk = ($urandom % 4) == 0;
      id = (r % 4 != 0) ? 3'($urandom % 2) : 3'($urandom % 8);
      we = ($urandom % 5) == 0;
      sel = 2'($urandom % 4);
      wd = (($urandom % 2) == 0) ? 32'hFFFF_FFFF : $urandom;
      step("R2 R3 R4 R5 R6 R7 R8 R9 random", v, 4'($urandom), id, lk, $urandom, we, sel, wd);
    end

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule